// File: doc/BRIEF.md
# Posted / Non-Posted Request Dispatcher

This block sits between an inbound request queue and two address-only output channels: a write-address channel and a read-address channel, each with a valid/ready handshake. Every incoming request carries a 3-bit kind code, a tag and a 64-bit address, plus a flag that says whether the address is 64-bit. Memory writes are queued in a posted FIFO. Memory reads, I/O reads and I/O writes are queued in a single non-posted FIFO, which keeps their relative order. Each output channel has a one-entry holding stage that is loaded from the FIFO heads.

A client-driven reject input stops non-posted requests from leaving the non-posted FIFO. A request already loaded into an output stage is still delivered. Posted writes keep moving to the write-address channel, so they overtake the non-posted requests that are blocked. When a posted write and a non-posted I/O write both compete for the write stage, the stage alternates between the two sources. Requests with a reserved kind code are discarded and raise a one-cycle error flag. Each FIFO reports full to the input side. A request presented while its FIFO is full is not taken.

Top module: `req_steer_dispatch`

## Requirements
- R1: Kind 3'b010 (memory write) leaves on the write-address channel. Kind 3'b011 (I/O write) also leaves on the write-address channel. Kinds 3'b000 (memory read) and 3'b001 (I/O read) leave on the read-address channel. Kind, tag and address are carried unchanged, except as R4 states.
- R2: Kinds 3'b100 to 3'b111 are dropped and never reach either channel. For each such request, `kind_err` is high for exactly the one cycle after the clock edge at which the request was presented.
- R3: Once `aw_valid` or `ar_valid` is high, it stays high with an unchanged kind, id and address until the matching ready is high at a clock edge. The transfer happens on that edge.
- R4: When `in_wide` is low, output address bits [63:32] are zero. When it is high, the full 64-bit address is passed through.
- R5: While `np_reject` is high, no non-posted request leaves the non-posted FIFO. No new read-address transfer and no new I/O write on the write-address channel are presented, whether the request was queued before the assertion or arrived after it.
- R6: A non-posted request already held in an output stage when `np_reject` rises stays presented until it is accepted.
- R7: Posted memory writes keep flowing to the write-address channel while `np_reject` is high.
- R8: When both the posted head and an eligible non-posted I/O write are waiting for the write stage, the grants alternate between the two sources.
- R9: Within each FIFO, requests leave in arrival order.
- R10: `post_full` and `npost_full` go high when the respective FIFO holds DEPTH entries. A request presented to a full FIFO is not accepted, and the FIFO never exceeds DEPTH entries.
- R11: After reset both valids, both full flags and `kind_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound request present this cycle |
| in_kind | input | 3 | Request kind code |
| in_tag | input | 8 | Request tag |
| in_addr | input | 64 | Request byte address |
| in_wide | input | 1 | High for a 64-bit address, low for 32-bit |
| post_full | output | 1 | Posted FIFO full |
| npost_full | output | 1 | Non-posted FIFO full |
| np_reject | input | 1 | Client cannot take non-posted requests |
| aw_valid | output | 1 | Write-address channel valid |
| aw_ready | input | 1 | Write-address channel ready |
| aw_addr | output | 64 | Write address |
| aw_id | output | 8 | Write tag |
| aw_kind | output | 3 | Write kind code |
| ar_valid | output | 1 | Read-address channel valid |
| ar_ready | input | 1 | Read-address channel ready |
| ar_addr | output | 64 | Read address |
| ar_id | output | 8 | Read tag |
| ar_kind | output | 3 | Read kind code |
| kind_err | output | 1 | One-cycle pulse for a dropped reserved-kind request |

## Verification
The bench sweeps all eight kind codes, alternating the address-width flag. A steering error shows up as a request on the wrong channel, a reserved code leaking out, or a missing error pulse. A missed address mask leaves stray upper bits. It raises the reject input while a read is parked in the read stage, then queues reads, I/O writes and memory writes behind it. This exposes a design that withdraws the parked read, lets a queued non-posted request slip out, or stalls posted writes together with the blocked ones. Another test stacks I/O writes and memory writes against a stalled write channel, which exposes a fixed-priority arbiter as an out-of-order grant sequence. A fill past DEPTH exposes a design that fails to raise full, or that overwrites or loses entries.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int KIND_W = 3;
  localparam int TAG_W  = 8;
  localparam int ADDR_W = 64;
  localparam int HALF_W = ADDR_W / 2;

  localparam logic [KIND_W-1:0] K_MEM_RD = 3'b000;
  localparam logic [KIND_W-1:0] K_IO_RD  = 3'b001;
  localparam logic [KIND_W-1:0] K_MEM_WR = 3'b010;
  localparam logic [KIND_W-1:0] K_IO_WR  = 3'b011;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
  } req_t;

  localparam int REQ_W = $bits(req_t);

  function automatic logic kind_reserved(input logic [KIND_W-1:0] k);
    return k[2];
  endfunction

  function automatic logic kind_posted(input logic [KIND_W-1:0] k);
    return k == K_MEM_WR;
  endfunction

  function automatic logic kind_nonposted(input logic [KIND_W-1:0] k);
    return !k[2] && (k != K_MEM_WR);
  endfunction

  function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
    return k[2:1] == 2'b00;
  endfunction

  function automatic logic [ADDR_W-1:0] fit_addr(input logic [ADDR_W-1:0] a,
                                                 input logic wide);
    return wide ? a : {{HALF_W{1'b0}}, a[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/rsd_fifo.sv
module rsd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [W-1:0]                  din,
  input  logic                          pop,
  output logic [W-1:0]                  dout,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign count = cnt_q;
endmodule

// File: rtl/rsd_wr_arb.sv
module rsd_wr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic p_req,
  input  logic n_req,
  output logic gnt_p,
  output logic gnt_n
);
  logic last_n;

  always_comb begin
    gnt_p = 1'b0;
    gnt_n = 1'b0;
    if (take) begin
      if (p_req && n_req) begin
        gnt_p = last_n;
        gnt_n = !last_n;
      end else begin
        gnt_p = p_req;
        gnt_n = n_req;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               last_n <= 1'b0;
    else if (gnt_p || gnt_n)  last_n <= gnt_n;
  end
endmodule

// File: rtl/rsd_chan_stage.sv
module rsd_chan_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  logic         v_q;
  logic [W-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     v_q <= 1'b0;
    else if (load)  v_q <= 1'b1;
    else if (ready) v_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) d_q <= din;
  end

  assign free  = !v_q || ready;
  assign valid = v_q;
  assign dout  = d_q;
endmodule

// File: rtl/req_steer_dispatch.sv
module req_steer_dispatch
  import rsd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [7:0]        in_tag,
  input  logic [63:0]       in_addr,
  input  logic              in_wide,
  output logic              post_full,
  output logic              npost_full,
  input  logic              np_reject,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [63:0]       aw_addr,
  output logic [7:0]        aw_id,
  output logic [2:0]        aw_kind,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [63:0]       ar_addr,
  output logic [7:0]        ar_id,
  output logic [2:0]        ar_kind,
  output logic              kind_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  req_t in_req, p_head, n_head, aw_load_req, aw_req, ar_req;
  logic [CNT_W-1:0] p_cnt, n_cnt;
  logic p_push, n_push, p_pop, n_pop;
  logic p_avail, n_avail, n_head_wr, n_head_rd;
  logic aw_free, ar_free, aw_gnt_p, aw_gnt_n, ar_load;
  logic err_q;

  assign in_req = '{kind: in_kind, tag: in_tag, addr: fit_addr(in_addr, in_wide)};

  assign post_full  = (p_cnt == FULL_CNT);
  assign npost_full = (n_cnt == FULL_CNT);
  assign p_push = in_valid && kind_posted(in_kind)    && !post_full;
  assign n_push = in_valid && kind_nonposted(in_kind) && !npost_full;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= in_valid && kind_reserved(in_kind);
  end
  assign kind_err = err_q;

  rsd_fifo #(.DEPTH(DEPTH), .W(REQ_W)) u_post_q (
    .clk(clk), .rst_n(rst_n), .push(p_push), .din(in_req),
    .pop(p_pop), .dout(p_head), .count(p_cnt)
  );

  rsd_fifo #(.DEPTH(DEPTH), .W(REQ_W)) u_npost_q (
    .clk(clk), .rst_n(rst_n), .push(n_push), .din(in_req),
    .pop(n_pop), .dout(n_head), .count(n_cnt)
  );

  assign p_avail   = (p_cnt != '0);
  assign n_avail   = (n_cnt != '0) && !np_reject;
  assign n_head_wr = n_avail && (n_head.kind == K_IO_WR);
  assign n_head_rd = n_avail && kind_is_read(n_head.kind);

  rsd_wr_arb u_wr_arb (
    .clk(clk), .rst_n(rst_n), .take(aw_free),
    .p_req(p_avail), .n_req(n_head_wr),
    .gnt_p(aw_gnt_p), .gnt_n(aw_gnt_n)
  );

  assign ar_load     = n_head_rd && ar_free;
  assign p_pop       = aw_gnt_p;
  assign n_pop       = aw_gnt_n || ar_load;
  assign aw_load_req = aw_gnt_p ? p_head : n_head;

  rsd_chan_stage #(.W(REQ_W)) u_aw_stage (
    .clk(clk), .rst_n(rst_n), .load(aw_gnt_p || aw_gnt_n), .din(aw_load_req),
    .ready(aw_ready), .valid(aw_valid), .dout(aw_req), .free(aw_free)
  );

  rsd_chan_stage #(.W(REQ_W)) u_ar_stage (
    .clk(clk), .rst_n(rst_n), .load(ar_load), .din(n_head),
    .ready(ar_ready), .valid(ar_valid), .dout(ar_req), .free(ar_free)
  );

  assign aw_addr = aw_req.addr;
  assign aw_id   = aw_req.tag;
  assign aw_kind = aw_req.kind;
  assign ar_addr = ar_req.addr;
  assign ar_id   = ar_req.tag;
  assign ar_kind = ar_req.kind;
endmodule

// File: rtl/req_steer_dispatch_chk.sv
module req_steer_dispatch_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [2:0]                 in_kind,
  input logic                       np_reject,
  input logic                       aw_valid,
  input logic                       aw_ready,
  input logic [63:0]                aw_addr,
  input logic [7:0]                 aw_id,
  input logic [2:0]                 aw_kind,
  input logic                       ar_valid,
  input logic                       ar_ready,
  input logic [63:0]                ar_addr,
  input logic [7:0]                 ar_id,
  input logic [2:0]                 ar_kind,
  input logic                       kind_err,
  input logic [$clog2(DEPTH+1)-1:0] p_cnt,
  input logic [$clog2(DEPTH+1)-1:0] n_cnt
);
  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_id) && $stable(aw_kind));

  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_id) && $stable(ar_kind));

  assert_aw_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> aw_kind[2:1] == 2'b01);

  assert_ar_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_kind[2:1] == 2'b00);

  assert_no_new_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    np_reject && !(ar_valid && !ar_ready) |=> !ar_valid);

  assert_no_new_iowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    np_reject && !(aw_valid && !aw_ready) |=> !(aw_valid && aw_kind == 3'b011));

  assert_parked_read_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    np_reject && ar_valid && !ar_ready |=> ar_valid && $stable(ar_id));

  assert_err_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kind_err) |-> $past(in_valid) && $past(in_kind[2]));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_cnt <= DEPTH) && (n_cnt <= DEPTH));
endmodule

bind req_steer_dispatch req_steer_dispatch_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
  .np_reject(np_reject),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id), .aw_kind(aw_kind),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_id(ar_id), .ar_kind(ar_kind),
  .kind_err(kind_err), .p_cnt(p_cnt), .n_cnt(n_cnt)
);

// File: tb/req_steer_dispatch_bench.sv
module req_steer_dispatch_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [7:0]  in_tag = '0;
  logic [63:0] in_addr = '0;
  logic        in_wide = 1'b0;
  logic        np_reject = 1'b0;
  logic        aw_ready = 1'b0;
  logic        ar_ready = 1'b0;
  logic        post_full, npost_full, aw_valid, ar_valid, kind_err;
  logic [63:0] aw_addr, ar_addr;
  logic [7:0]  aw_id, ar_id;
  logic [2:0]  aw_kind, ar_kind;

  req_steer_dispatch #(.DEPTH(DEPTH)) u_req_steer_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind), .in_tag(in_tag),
    .in_addr(in_addr), .in_wide(in_wide), .post_full(post_full), .npost_full(npost_full),
    .np_reject(np_reject), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_id(aw_id), .aw_kind(aw_kind), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_id(ar_id), .ar_kind(ar_kind), .kind_err(kind_err)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]  aw_log_id [256];
  logic [2:0]  aw_log_kind [256];
  logic [63:0] aw_log_addr [256];
  logic [7:0]  ar_log_id [256];
  logic [2:0]  ar_log_kind [256];
  logic [63:0] ar_log_addr [256];
  int aw_n = 0;
  int ar_n = 0;
  int err_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (aw_valid && aw_ready) begin
        aw_log_id[aw_n[7:0]] = aw_id;
        aw_log_kind[aw_n[7:0]] = aw_kind;
        aw_log_addr[aw_n[7:0]] = aw_addr;
        aw_n++;
      end
      if (ar_valid && ar_ready) begin
        ar_log_id[ar_n[7:0]] = ar_id;
        ar_log_kind[ar_n[7:0]] = ar_kind;
        ar_log_addr[ar_n[7:0]] = ar_addr;
        ar_n++;
      end
      if (kind_err) err_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [7:0] t,
                      input logic [63:0] a, input logic w);
    in_valid = 1'b1; in_kind = k; in_tag = t; in_addr = a; in_wide = w;
    step(1);
    in_valid = 1'b0;
    step(1);
  endtask

  function automatic logic [63:0] exp_addr(input logic [63:0] a, input logic w);
    return w ? a : (a & 64'h0000_0000_FFFF_FFFF);
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    if (!finished) begin
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    #2;
    // R11 reset state
    chk(!aw_valid && !ar_valid, "R11", "valids after reset", {aw_valid, ar_valid}, 0);
    chk(!post_full && !npost_full, "R11", "fulls after reset", {post_full, npost_full}, 0);
    chk(!kind_err, "R11", "kind_err after reset", kind_err, 0);
    step(1);

    // R1 R2 R4: sweep all kind codes, both address widths
    aw_ready = 1'b1; ar_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int w = 0; w < 2; w++) begin
        int aw0, ar0, er0;
        logic [63:0] a;
        logic [7:0] t;
        aw0 = aw_n; ar0 = ar_n; er0 = err_n;
        a = 64'hA5C3_0F00_1234_5670 + 64'(k * 16 + w);
        t = 8'(8'h40 + k * 2 + w);
        push(3'(k), t, a, w[0]);
        step(5);
        if (k >= 4) begin
          chk(aw_n == aw0 && ar_n == ar0, "R2", "reserved kind leaked", aw_n + ar_n - aw0 - ar0, 0);
          chk(err_n == er0 + 1, "R2", "kind_err pulse count", err_n - er0, 1);
        end else if (k >= 2) begin
          chk(aw_n == aw0 + 1 && ar_n == ar0, "R1", "write kind on aw only", aw_n - aw0, 1);
          chk(aw_log_id[aw0[7:0]] == t && aw_log_kind[aw0[7:0]] == 3'(k), "R1", "aw id/kind",
              {aw_log_id[aw0[7:0]], aw_log_kind[aw0[7:0]]}, {t, 3'(k)});
          chk(aw_log_addr[aw0[7:0]] == exp_addr(a, w[0]), "R4", "aw address mask",
              aw_log_addr[aw0[7:0]], exp_addr(a, w[0]));
          chk(err_n == er0, "R2", "no kind_err on legal kind", err_n - er0, 0);
        end else begin
          chk(ar_n == ar0 + 1 && aw_n == aw0, "R1", "read kind on ar only", ar_n - ar0, 1);
          chk(ar_log_id[ar0[7:0]] == t && ar_log_kind[ar0[7:0]] == 3'(k), "R1", "ar id/kind",
              {ar_log_id[ar0[7:0]], ar_log_kind[ar0[7:0]]}, {t, 3'(k)});
          chk(ar_log_addr[ar0[7:0]] == exp_addr(a, w[0]), "R4", "ar address mask",
              ar_log_addr[ar0[7:0]], exp_addr(a, w[0]));
        end
      end
    end

    // R2: kind_err lasts exactly one cycle, one cycle after presentation
    in_valid = 1'b1; in_kind = 3'b110; in_tag = 8'h77; in_wide = 1'b1;
    chk(!kind_err, "R2", "kind_err before edge", kind_err, 0);
    step(1);
    in_valid = 1'b0;
    chk(kind_err, "R2", "kind_err after edge", kind_err, 1);
    step(1);
    chk(!kind_err, "R2", "kind_err one cycle", kind_err, 0);
    step(2);

    // R5 R6 R7: reject with a parked read
    begin
      int aw0, ar0;
      ar_ready = 1'b0; aw_ready = 1'b0;
      push(3'b000, 8'h11, 64'h1000, 1'b1);
      chk(ar_valid && ar_id == 8'h11, "R6", "read parked", ar_id, 8'h11);
      np_reject = 1'b1;
      aw_ready = 1'b1;
      aw0 = aw_n; ar0 = ar_n;
      push(3'b000, 8'h12, 64'h2000, 1'b1);
      push(3'b011, 8'h14, 64'h4000, 1'b1);
      push(3'b010, 8'h13, 64'h3000, 1'b1);
      step(6);
      chk(ar_valid && ar_id == 8'h11, "R6", "parked read still presented", ar_id, 8'h11);
      chk(aw_n == aw0 + 1 && aw_log_id[aw0[7:0]] == 8'h13, "R7", "posted write overtakes",
          aw_log_id[aw0[7:0]], 8'h13);
      ar_ready = 1'b1;
      step(6);
      chk(ar_n == ar0 + 1 && ar_log_id[ar0[7:0]] == 8'h11, "R6", "parked read delivered",
          ar_n - ar0, 1);
      chk(aw_n == aw0 + 1, "R5", "io write held while rejected", aw_n - aw0, 1);
      chk(!ar_valid, "R5", "queued read held while rejected", ar_valid, 0);
      np_reject = 1'b0;
      step(8);
      chk(ar_n == ar0 + 2 && ar_log_id[(ar0 + 1) & 255] == 8'h12, "R5", "read released",
          ar_log_id[(ar0 + 1) & 255], 8'h12);
      chk(aw_n == aw0 + 2 && aw_log_id[(aw0 + 1) & 255] == 8'h14, "R5", "io write released",
          aw_log_id[(aw0 + 1) & 255], 8'h14);
    end

    // R8 R9: round-robin on the write stage
    begin
      int aw0;
      logic [7:0] exp_ids [4];
      exp_ids = '{8'h21, 8'h22, 8'h23, 8'h24};
      aw_ready = 1'b0;
      aw0 = aw_n;
      push(3'b011, 8'h21, 64'h100, 1'b0);
      push(3'b010, 8'h22, 64'h200, 1'b0);
      push(3'b011, 8'h23, 64'h300, 1'b0);
      push(3'b010, 8'h24, 64'h400, 1'b0);
      aw_ready = 1'b1;
      step(8);
      chk(aw_n == aw0 + 4, "R8", "write grants count", aw_n - aw0, 4);
      for (int i = 0; i < 4; i++)
        chk(aw_log_id[(aw0 + i) & 255] == exp_ids[i], "R8", "alternating grant order",
            aw_log_id[(aw0 + i) & 255], exp_ids[i]);
    end

    // R10 R9: fill the posted FIFO past DEPTH
    begin
      int aw0;
      aw_ready = 1'b0;
      aw0 = aw_n;
      for (int i = 0; i < DEPTH + 3; i++)
        push(3'b010, 8'(8'h30 + i), 64'h5000 + 64'(i), 1'b1);
      chk(post_full, "R10", "post_full at DEPTH", post_full, 1);
      chk(!npost_full, "R10", "npost_full stays low", npost_full, 0);
      aw_ready = 1'b1;
      step(DEPTH + 6);
      chk(aw_n == aw0 + DEPTH + 1, "R10", "entries kept when full", aw_n - aw0, DEPTH + 1);
      for (int i = 0; i < DEPTH + 1; i++)
        chk(aw_log_id[(aw0 + i) & 255] == 8'(8'h30 + i), "R9", "posted order",
            aw_log_id[(aw0 + i) & 255], 8'(8'h30 + i));
      chk(!post_full, "R10", "post_full clears", post_full, 0);
    end

    // R10: fill the non-posted FIFO behind a reject
    begin
      np_reject = 1'b1;
      for (int i = 0; i < DEPTH + 1; i++)
        push(3'b001, 8'(8'h50 + i), 64'h6000, 1'b1);
      chk(npost_full, "R10", "npost_full at DEPTH", npost_full, 1);
      chk(!ar_valid, "R5", "no read while rejected", ar_valid, 0);
      np_reject = 1'b0;
      step(DEPTH + 6);
      chk(!npost_full && !ar_valid, "R10", "npost drained", {npost_full, ar_valid}, 0);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule